// File: doc/BRIEF.md
# Serial DAC Command Frame Sequencer

This block sits on the host side of a three-wire link to a voltage-output DAC. A client hands it a 2-bit output mode and a DAC code over a valid/ready handshake. The block packs them into one 16-bit command word and drives an active-low frame select, a serial clock that idles low and a data line. Each bit changes on a rising clock edge, so it is stable at the falling edge where the DAC samples it. The word goes out most significant bit first. When the last bit is out, the block pulses `done` and returns to idle.

All timing is counted in system clock cycles and set by parameters:
- the serial clock high and low phases;
- the setup from frame select falling to the first clock edge;
- the minimum time frame select stays high before a frame;
- the pause between the two bytes in split mode.

Choose the half-period so that each phase lasts at least 5 ns and the serial clock stays at or below 30 MHz. At the default 4 ns system clock, five cycles per phase gives 25 MHz.

Two per-request options are sampled when a request is accepted:
- **Split mode** sends the word as two 8-bit bursts with a pause between them. Frame select stays low across both bursts.
- **Low-power park** leaves frame select low after the frame. The next frame still begins with frame select driven high for the full gap time.

Top module: `dac_frame_tx`

## Requirements
- R1: Out of reset, frame select is high, the serial clock and data are low, `req_ready` is high, and `busy` and `done` are low.
- R2: The transmitted word carries the mode in bits 15:14 and the code in bits 13 down to 14-CODE_W, code MSB first. Any lower bits are zero. Bit 15 goes out first.
- R3: The serial clock is low whenever frame select is high. Each high phase lasts exactly HALF_DIV cycles, and so does each low phase inside a byte. Data changes only together with a rising edge and holds while the clock is high.
- R4: A frame has exactly 16 falling serial clock edges while frame select is low, and never more.
- R5: The first rising serial clock edge comes exactly SETUP_CYC cycles after frame select falls.
- R6: Before every falling edge of frame select, frame select has been high for at least GAP_CYC cycles.
- R7: In split mode the clock stays low for HALF_DIV+BYTE_GAP_CYC cycles after the 8th falling edge. Frame select stays low until the frame ends.
- R8: With park selected, frame select stays low after the frame and while idle. The next frame then raises it for at least GAP_CYC cycles before lowering it.
- R9: `req_ready` is high only while idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle until the frame ends. Every accepted request produces exactly one frame.
- R10: `done` is a one-cycle pulse HALF_DIV cycles after the 16th falling edge. In the same cycle, frame select rises unless park was selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 2 | Output mode field for the command word |
| req_code | input | CODE_W | DAC code |
| cfg_split | input | 1 | Send the word as two 8-bit bursts |
| cfg_park_low | input | 1 | Leave frame select low after the frame |
| dac_cs_n | output | 1 | Frame select, active low |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data, valid at falling clock edges |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
Every output is a register, so each event shows up exactly one sample after the edge that causes it:
- the first rising edge comes SETUP_CYC samples after frame select falls;
- each clock phase lasts HALF_DIV samples, or HALF_DIV+BYTE_GAP_CYC after the first byte in split mode;
- `done` comes HALF_DIV samples after the last falling edge.

A monitor samples the pins mid-cycle and keeps a run-length counter for each of these intervals. It compares each counter exactly at the transition that ends the interval. It rebuilds the word from the data captured at the falling edges, then compares it at the `done` pulse against the item the driver queued when the request was accepted.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_BGAP
    } tx_state_e;

    typedef struct packed {
        tx_state_e   state;
        logic        cs_n;
        logic        sclk;
        logic        sdo;
        logic        done;
        logic        split;
        logic        park;
        logic [4:0]  falls;
        logic [15:0] shreg;
    } tx_regs_t;

    localparam int unsigned WORD_W = 16;

endpackage

// File: rtl/dac_tx_pack.sv
module dac_tx_pack #(
    parameter int unsigned CODE_W = 12
) (
    input  logic [1:0]        mode,
    input  logic [CODE_W-1:0] code,
    output logic [15:0]       word
);
    localparam int unsigned PAD_W = 14 - CODE_W;

    generate
        if (PAD_W == 0) begin : g_full
            assign word = {mode, code};
        end else begin : g_pad
            assign word = {mode, code, {PAD_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int unsigned CODE_W      = 12,
    parameter int unsigned HALF_DIV    = 5,
    parameter int unsigned SETUP_CYC   = 3,
    parameter int unsigned GAP_CYC     = 9,
    parameter int unsigned BYTE_GAP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_mode,
    input  logic [CODE_W-1:0] req_code,
    input  logic              cfg_split,
    input  logic              cfg_park_low,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              busy,
    output logic              done
);
    localparam int unsigned MAX_A = (HALF_DIV > SETUP_CYC) ? HALF_DIV : SETUP_CYC;
    localparam int unsigned MAX_B = (GAP_CYC > BYTE_GAP_CYC) ? GAP_CYC : BYTE_GAP_CYC;
    localparam int unsigned MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W = $clog2(MAX_V + 1);
    localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] BGAP_LD  = CNT_W'(BYTE_GAP_CYC - 1);
    localparam logic [4:0] LAST_FALL = 5'(WORD_W);
    localparam logic [4:0] MID_FALL  = 5'(WORD_W / 2);

    tx_regs_t         regs_d, regs_q;
    logic [15:0]      packed_word;
    logic             tm_load;
    logic [CNT_W-1:0] tm_val;
    logic             tm_exp;
    logic             launch;

    dac_tx_pack #(.CODE_W(CODE_W)) i_pack (
        .mode (req_mode),
        .code (req_code),
        .word (packed_word)
    );

    dac_tx_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_exp)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        tm_load     = 1'b0;
        tm_val      = '0;
        launch      = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.state = ST_PRE;
                    regs_d.cs_n  = 1'b1;
                    regs_d.shreg = packed_word;
                    regs_d.split = cfg_split;
                    regs_d.park  = cfg_park_low;
                    regs_d.falls = '0;
                    tm_load      = 1'b1;
                    tm_val       = GAP_LD;
                end
            end
            ST_PRE: begin
                if (tm_exp) begin
                    regs_d.state = ST_SETUP;
                    regs_d.cs_n  = 1'b0;
                    tm_load      = 1'b1;
                    tm_val       = SETUP_LD;
                end
            end
            ST_SETUP, ST_BGAP: begin
                launch = tm_exp;
            end
            ST_HIGH: begin
                if (tm_exp) begin
                    regs_d.state = ST_LOW;
                    regs_d.sclk  = 1'b0;
                    regs_d.falls = regs_q.falls + 1'b1;
                    tm_load      = 1'b1;
                    tm_val       = HALF_LD;
                end
            end
            ST_LOW: begin
                if (tm_exp) begin
                    if (regs_q.falls == LAST_FALL) begin
                        regs_d.state = ST_IDLE;
                        regs_d.done  = 1'b1;
                        regs_d.cs_n  = ~regs_q.park;
                        regs_d.sdo   = 1'b0;
                    end else if (regs_q.split && regs_q.falls == MID_FALL) begin
                        regs_d.state = ST_BGAP;
                        tm_load      = 1'b1;
                        tm_val       = BGAP_LD;
                    end else begin
                        launch = 1'b1;
                    end
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase
        if (launch) begin
            regs_d.state = ST_HIGH;
            regs_d.sclk  = 1'b1;
            regs_d.sdo   = regs_q.shreg[15];
            regs_d.shreg = {regs_q.shreg[14:0], 1'b0};
            tm_load      = 1'b1;
            tm_val       = HALF_LD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.state <= ST_IDLE;
            regs_q.cs_n  <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready = (regs_q.state == ST_IDLE);
    assign busy      = (regs_q.state != ST_IDLE);
    assign dac_cs_n  = regs_q.cs_n;
    assign dac_sclk  = regs_q.sclk;
    assign dac_sdo   = regs_q.sdo;
    assign done      = regs_q.done;

    // Independent count of falling clock edges per frame, for R4
    logic [4:0] chk_falls_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_falls_q <= '0;
        end else if (!busy) begin
            chk_falls_q <= '0;
        end else if (dac_sclk && !regs_d.sclk) begin
            chk_falls_q <= chk_falls_q + 1'b1;
        end
    end

    a_r3_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk);

    a_r3_sdo_holds_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));

    a_r4_no_extra_falls: assert property (@(posedge clk) disable iff (!rst_n)
        chk_falls_q <= 5'd16);

    a_r5_rise_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> (!dac_cs_n && !$past(dac_cs_n)));

    a_r6_select_falls_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> busy);

    a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/test_dac_frame_tx.sv
module test_dac_frame_tx;
    localparam int CW    = 12;
    localparam int HALF  = 5;
    localparam int SETUP = 3;
    localparam int GAP   = 9;
    localparam int BGAP  = 4;

    typedef struct {
        logic [15:0] word;
        logic        split;
        logic        park;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_mode = '0;
    logic [CW-1:0] req_code = '0;
    logic          cfg_split = 1'b0;
    logic          cfg_park_low = 1'b0;
    logic          dac_cs_n, dac_sclk, dac_sdo, busy, done;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t expq[$];

    always #2 clk = ~clk;

    dac_frame_tx #(
        .CODE_W(CW), .HALF_DIV(HALF), .SETUP_CYC(SETUP),
        .GAP_CYC(GAP), .BYTE_GAP_CYC(BGAP)
    ) i_dac_frame_tx (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_code(req_code), .cfg_split(cfg_split),
        .cfg_park_low(cfg_park_low), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk),
        .dac_sdo(dac_sdo), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [1:0] mode, input logic [CW-1:0] code,
                        input logic split, input logic park);
        exp_t e;
        @(negedge clk);
        req_mode = mode; req_code = code; cfg_split = split; cfg_park_low = park;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        e.word  = (16'(mode) << 14) | (16'(code) << (14 - CW));
        e.split = split;
        e.park  = park;
        expq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    initial begin
        logic p_cs, p_sclk, p_sdo, first_rise;
        int cs_hi, setup_n, hi_n, lo_n, nfalls, exp_lo;
        logic [15:0] word;
        exp_t e;
        p_cs = 1'b1; p_sclk = 1'b0; p_sdo = 1'b0; first_rise = 1'b0;
        cs_hi = 0; setup_n = 0; hi_n = 0; lo_n = 0; nfalls = 0; word = '0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (dac_cs_n && dac_sclk) check(1'b0, "R3 sclk high while deselected", 1, 0);
            if (busy && req_ready) check(1'b0, "R9 ready while busy", 1, 0);
            if (p_cs && !dac_cs_n) begin
                check(cs_hi >= GAP, "R6 select high time", cs_hi, GAP);
                setup_n = 0; nfalls = 0; word = '0; first_rise = 1'b1;
            end
            if (!p_sclk && dac_sclk) begin
                if (first_rise) begin
                    check(setup_n == SETUP, "R5 setup cycles", setup_n, SETUP);
                end else begin
                    exp_lo = HALF;
                    if (expq.size() > 0 && expq[0].split && nfalls == 8) exp_lo = HALF + BGAP;
                    check(lo_n == exp_lo, (exp_lo != HALF) ? "R7 byte pause" : "R3 low phase",
                          lo_n, exp_lo);
                end
                first_rise = 1'b0;
                hi_n = 0;
            end
            if (p_sclk && dac_sclk && (dac_sdo != p_sdo))
                check(1'b0, "R3 data changed while clock high", dac_sdo, p_sdo);
            if (p_sclk && !dac_sclk) begin
                check(hi_n == HALF, "R3 high phase", hi_n, HALF);
                word = {word[14:0], dac_sdo};
                nfalls++;
                lo_n = 0;
                if (dac_cs_n) check(1'b0, "R7 select rose mid frame", 1, 0);
            end
            if (done) begin
                check(nfalls == 16, "R4 falling edges per frame", nfalls, 16);
                check(lo_n == HALF, "R10 done delay after last fall", lo_n, HALF);
                if (expq.size() == 0) begin
                    check(1'b0, "R9 frame without request", 1, 0);
                end else begin
                    e = expq.pop_front();
                    check(word == e.word, "R2 frame word", word, e.word);
                    check(dac_cs_n == !e.park, e.park ? "R8 parked select" : "R10 select rises",
                          dac_cs_n, !e.park);
                end
            end
            if (dac_cs_n) cs_hi++; else cs_hi = 0;
            if (!dac_cs_n) setup_n++;
            if (dac_sclk) hi_n++; else lo_n++;
            p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdo = dac_sdo;
        end
    end

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk);
                check(dac_cs_n == 1'b1, "R1 reset select", dac_cs_n, 1);
                check({dac_sclk, dac_sdo, busy, done} == 4'b0, "R1 reset outputs",
                      {dac_sclk, dac_sdo, busy, done}, 0);
                check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
                rst_n = 1'b1;
                send(2'd0, 12'hABC, 1'b0, 1'b0);
                send(2'd3, 12'h000, 1'b0, 1'b0);
                send(2'd1, 12'hFFF, 1'b0, 1'b0);
                send(2'd2, 12'h555, 1'b1, 1'b0);
                send(2'd0, 12'h123, 1'b1, 1'b1);
                wait (expq.size() == 0);
                repeat (12) @(negedge clk);
                check(dac_cs_n == 1'b0, "R8 select parked while idle", dac_cs_n, 0);
                check(busy == 1'b0, "R9 idle after frame", busy, 0);
                send(2'd1, 12'h800, 1'b0, 1'b1);
                send(2'd2, 12'h001, 1'b0, 1'b0);
                send(2'd3, 12'hA5A, 1'b1, 1'b0);
                wait (expq.size() == 0);
                repeat (20) @(negedge clk);
                check(dac_cs_n == 1'b1 && busy == 1'b0, "R9 final idle", dac_cs_n, 1);
                check(expq.size() == 0, "R9 every request framed", expq.size(), 0);
                finished = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule